// File: doc/BRIEF.md
# Micro-op Dispatch Gate

This block sits between instruction decode and the out-of-order back end. It takes one decoded instruction per cycle over a valid/ready handshake. Each instruction is tagged with its micro-op count and its number of destination registers. In every cycle the block decides whether that instruction may go to the scheduler. The decision weighs a per-cycle micro-op bandwidth against three free-count inputs: reorder-buffer slots, free rename registers and scheduler buffer entries.

An instruction wider than the bandwidth is still admitted, but only in a cycle whose bandwidth is completely untouched. The micro-ops it has beyond the bandwidth are remembered as a carry-over. The carry-over eats into the bandwidth of the cycles that follow until it is worked off. On every accepted instruction the block emits a one-cycle allocation pulse carrying the micro-op and destination counts. It also keeps one saturating stall counter per blocking cause, and these counters can be read through a small select/data port.

Top module: `uop_dispatch_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the carry-over, the allocation pulse and all stall counters, so the full bandwidth of DISP_W micro-ops is available in the first cycle after reset.
- R2: in_ready is low whenever in_uops exceeds rob_free; equality is sufficient.
- R3: in_ready is low whenever in_dests exceeds ren_free; equality is sufficient.
- R4: in_ready is low whenever in_uops exceeds sch_free; equality is sufficient.
- R5: A blocked cycle is charged to exactly one cause, chosen in this priority: bandwidth, then reorder buffer, then rename registers, then scheduler.
- R6: With carry-over C, the free bandwidth in a cycle is max(DISP_W - C, 0). An instruction fits if in_uops is no larger than that, or if C is zero (full bandwidth unused).
- R7: When an instruction with in_uops greater than DISP_W is accepted, the carry-over becomes in_uops - DISP_W. Each later cycle subtracts up to DISP_W from it.
- R8: The cycle after a handshake (in_valid and in_ready both high at a clock edge), alloc_vld is high for one cycle, with alloc_uops and alloc_dests equal to the accepted counts. Otherwise alloc_vld is low.
- R9: Each cycle with in_valid high and in_ready low adds one to the counter of the cause charged under R5.
- R10: Stall counters saturate at all ones and never wrap.
- R11: rd_data shows the counter chosen by rd_sel: 0 reorder buffer, 1 rename registers, 2 scheduler, 3 bandwidth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_uops | input | UOP_W | Micro-op count of the instruction |
| in_dests | input | DST_W | Destination register count |
| in_ready | output | 1 | Instruction may be accepted this cycle |
| rob_free | input | FREE_W | Free reorder-buffer slots |
| ren_free | input | FREE_W | Free rename registers |
| sch_free | input | FREE_W | Free scheduler buffer entries |
| alloc_vld | output | 1 | Allocation pulse, one cycle after acceptance |
| alloc_uops | output | UOP_W | Micro-ops to allocate |
| alloc_dests | output | DST_W | Rename registers to allocate |
| rd_sel | input | 2 | Stall counter select |
| rd_data | output | CNT_W | Selected stall counter |

## Verification
A bandwidth shortfall left by carry-over can coincide with a reorder-buffer shortage in the same cycle. Only one cause may be charged in that case. The bench provokes this with an oversized instruction followed by a narrow one, offered while rob_free is held at zero. It then reads both counters and expects the bandwidth count to rise while the reorder-buffer count stays unchanged. A second overlap is between carry-over being worked off and a new instruction that exactly fills the remaining slots. Here the bench expects acceptance together with an allocation pulse on the next cycle.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int N_CAUSE = 4;
  typedef enum logic [1:0] {
    CAUSE_ROB = 2'd0,
    CAUSE_REN = 2'd1,
    CAUSE_SCH = 2'd2,
    CAUSE_BW  = 2'd3
  } cause_e;

  // slots left this cycle given outstanding carry-over
  function automatic int slots_free(input int carry, input int width);
    return (carry >= width) ? 0 : width - carry;
  endfunction

  // an instruction fits if it is within the free slots or the cycle is untouched
  function automatic logic may_fit(input int uops, input int avail, input int width);
    return (uops <= avail) || (avail == width);
  endfunction

  // carry-over left for the next cycle
  function automatic int carry_after(input int carry, input int width,
                                     input logic took, input int uops,
                                     input int avail);
    int rest;
    rest = (carry >= width) ? carry - width : 0;
    if (took && uops > avail) rest = rest + (uops - avail);
    return rest;
  endfunction
endpackage

// File: rtl/dc_slot_trk.sv
module dc_slot_trk #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [UOP_W-1:0] uops,
  output logic [UOP_W-1:0] carry,
  output logic [UOP_W-1:0] avail,
  output logic             fits
);
  logic [UOP_W-1:0] carry_q;
  int               avail_i;

  always_comb begin
    avail_i = dc_pkg::slots_free(int'(carry_q), DISP_W);
    avail   = UOP_W'(avail_i);
    fits    = dc_pkg::may_fit(int'(uops), avail_i, DISP_W);
  end

  always_ff @(posedge clk) begin
    if (rst) carry_q <= '0;
    else     carry_q <= UOP_W'(dc_pkg::carry_after(int'(carry_q), DISP_W, take,
                                                   int'(uops), avail_i));
  end

  assign carry = carry_q;
endmodule

// File: rtl/dc_res_check.sv
module dc_res_check #(
  parameter int UOP_W  = 4,
  parameter int DST_W  = 3,
  parameter int FREE_W = 6
) (
  input  logic [UOP_W-1:0]  uops,
  input  logic [DST_W-1:0]  dests,
  input  logic [FREE_W-1:0] rob_free,
  input  logic [FREE_W-1:0] ren_free,
  input  logic [FREE_W-1:0] sch_free,
  output logic              ok,
  output logic [2:0]        first_fail
);
  logic [2:0] short_v;

  always_comb begin
    short_v[0] = int'(uops)  > int'(rob_free);
    short_v[1] = int'(dests) > int'(ren_free);
    short_v[2] = int'(uops)  > int'(sch_free);
  end

  // lowest index wins: reorder buffer, then rename, then scheduler
  for (genvar i = 0; i < 3; i++) begin : g_prio
    if (i == 0) begin : g_first
      assign first_fail[i] = short_v[i];
    end else begin : g_rest
      assign first_fail[i] = short_v[i] && (short_v[i-1:0] == '0);
    end
  end

  assign ok = (short_v == '0);
endmodule

// File: rtl/dc_stall_cnt.sv
module dc_stall_cnt #(
  parameter int CNT_W = 32,
  parameter int N     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         evt,
  input  logic [$clog2(N)-1:0] sel,
  output logic [CNT_W-1:0]     data
);
  logic [CNT_W-1:0] cnt [N];

  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                          cnt[i] <= '0;
      else if (evt[i] && cnt[i] != '1) cnt[i] <= cnt[i] + 1'b1;
    end
  end

  assign data = cnt[sel];
endmodule

// File: rtl/uop_dispatch_ctrl.sv
module uop_dispatch_ctrl #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int DST_W  = 3,
  parameter int FREE_W = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [UOP_W-1:0]  in_uops,
  input  logic [DST_W-1:0]  in_dests,
  output logic              in_ready,
  input  logic [FREE_W-1:0] rob_free,
  input  logic [FREE_W-1:0] ren_free,
  input  logic [FREE_W-1:0] sch_free,
  output logic              alloc_vld,
  output logic [UOP_W-1:0]  alloc_uops,
  output logic [DST_W-1:0]  alloc_dests,
  input  logic [1:0]        rd_sel,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int NC = dc_pkg::N_CAUSE;

  // named internal events
  logic             fire;
  logic             fits;
  logic             res_ok;
  logic [2:0]       first_fail;
  logic [UOP_W-1:0] carry;
  logic [UOP_W-1:0] avail;
  logic [NC-1:0]    stall_evt;

  dc_slot_trk #(.DISP_W(DISP_W), .UOP_W(UOP_W)) u_slot (
    .clk(clk), .rst(rst), .take(fire), .uops(in_uops),
    .carry(carry), .avail(avail), .fits(fits)
  );

  dc_res_check #(.UOP_W(UOP_W), .DST_W(DST_W), .FREE_W(FREE_W)) u_res (
    .uops(in_uops), .dests(in_dests), .rob_free(rob_free),
    .ren_free(ren_free), .sch_free(sch_free),
    .ok(res_ok), .first_fail(first_fail)
  );

  assign in_ready = fits && res_ok;
  assign fire     = in_valid && in_ready;

  always_comb begin
    stall_evt = '0;
    if (in_valid && !fits) stall_evt[dc_pkg::CAUSE_BW] = 1'b1;
    else if (in_valid)     stall_evt[2:0] = first_fail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_vld   <= 1'b0;
      alloc_uops  <= '0;
      alloc_dests <= '0;
    end else begin
      alloc_vld <= fire;
      if (fire) begin
        alloc_uops  <= in_uops;
        alloc_dests <= in_dests;
      end
    end
  end

  dc_stall_cnt #(.CNT_W(CNT_W), .N(NC)) u_cnt (
    .clk(clk), .rst(rst), .evt(stall_evt), .sel(rd_sel), .data(rd_data)
  );
endmodule

// File: rtl/uop_dispatch_ctrl_chk.sv
module uop_dispatch_ctrl_chk #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int DST_W  = 3,
  parameter int FREE_W = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [UOP_W-1:0]  in_uops,
  input logic [DST_W-1:0]  in_dests,
  input logic              in_ready,
  input logic [FREE_W-1:0] rob_free,
  input logic [FREE_W-1:0] ren_free,
  input logic [FREE_W-1:0] sch_free,
  input logic              alloc_vld,
  input logic [UOP_W-1:0]  alloc_uops,
  input logic [DST_W-1:0]  alloc_dests,
  input logic [1:0]        rd_sel,
  input logic [CNT_W-1:0]  rd_data,
  input logic [UOP_W-1:0]  carry,
  input logic [3:0]        stall_evt
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (carry == '0 && !alloc_vld));
  p_rob_r2: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> int'(in_uops) <= int'(rob_free));
  p_ren_r3: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> int'(in_dests) <= int'(ren_free));
  p_sch_r4: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> int'(in_uops) <= int'(sch_free));
  p_one_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stall_evt));
  p_bw_r6: assert property (@(posedge clk) disable iff (rst)
    (in_ready && carry != '0) |-> int'(in_uops) + int'(carry) <= DISP_W);
  p_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && carry == '0 && int'(in_uops) > DISP_W)
      |=> int'(carry) == int'($past(in_uops)) - DISP_W);
  p_alloc_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (alloc_vld && alloc_uops == $past(in_uops)
                                && alloc_dests == $past(in_dests)));
  p_no_alloc_r8: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !alloc_vld);
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |-> $countones(stall_evt) == 1);
  p_sat_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_data) == '1 && $stable(rd_sel)) |-> rd_data == '1);
endmodule

bind uop_dispatch_ctrl uop_dispatch_ctrl_chk #(
  .DISP_W(DISP_W), .UOP_W(UOP_W), .DST_W(DST_W), .FREE_W(FREE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
  .in_dests(in_dests), .in_ready(in_ready), .rob_free(rob_free),
  .ren_free(ren_free), .sch_free(sch_free), .alloc_vld(alloc_vld),
  .alloc_uops(alloc_uops), .alloc_dests(alloc_dests), .rd_sel(rd_sel),
  .rd_data(rd_data), .carry(carry), .stall_evt(stall_evt)
);

// File: tb/sim_uop_dispatch_ctrl.sv
module sim_uop_dispatch_ctrl;
  localparam int DW = 4, UW = 4, TW = 3, FW = 6, CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [UW-1:0] in_uops = '0;
  logic [TW-1:0] in_dests = '0;
  logic          in_ready;
  logic [FW-1:0] rob_free = '1, ren_free = '1, sch_free = '1;
  logic          alloc_vld;
  logic [UW-1:0] alloc_uops;
  logic [TW-1:0] alloc_dests;
  logic [1:0]    rd_sel = '0;
  logic [CW-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uop_dispatch_ctrl #(.DISP_W(DW), .UOP_W(UW), .DST_W(TW), .FREE_W(FW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
    .in_dests(in_dests), .in_ready(in_ready), .rob_free(rob_free),
    .ren_free(ren_free), .sch_free(sch_free), .alloc_vld(alloc_vld),
    .alloc_uops(alloc_uops), .alloc_dests(alloc_dests), .rd_sel(rd_sel),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int u, input int d,
                       input int rob, input int ren, input int sch);
    in_valid = v; in_uops = UW'(u); in_dests = TW'(d);
    rob_free = FW'(rob); ren_free = FW'(ren); sch_free = FW'(sch);
    #1;
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic counter(input int sel, input string req, input int exp);
    rd_sel = 2'(sel); #1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic t_reset;
    drive(0, 1, 1, 63, 63, 63);
    chk("R1 alloc_vld after reset", int'(alloc_vld), 0);
    chk("R1 ready at full bandwidth", int'(in_ready), 1);
    for (int s = 0; s < 4; s++) counter(s, "R1/R11 counter cleared", 0);
  endtask

  task automatic t_basic;
    drive(1, 3, 2, 63, 63, 63);
    chk("R8 ready", int'(in_ready), 1);
    tick; drive(0, 3, 2, 63, 63, 63);
    chk("R8 alloc_vld", int'(alloc_vld), 1);
    chk("R8 alloc_uops", int'(alloc_uops), 3);
    chk("R8 alloc_dests", int'(alloc_dests), 2);
    tick;
    chk("R8 pulse one cycle", int'(alloc_vld), 0);
  endtask

  task automatic t_rob;
    drive(1, 3, 1, 2, 63, 63);
    chk("R2 short rob blocks", int'(in_ready), 0);
    tick;
    chk("R2 no alloc", int'(alloc_vld), 0);
    drive(1, 3, 1, 3, 63, 63);
    chk("R2 equal rob ok", int'(in_ready), 1);
    drive(0, 3, 1, 3, 63, 63);
    counter(0, "R9/R11 rob counter", 1);
  endtask

  task automatic t_ren;
    drive(1, 1, 2, 63, 1, 63);
    chk("R3 short rename blocks", int'(in_ready), 0);
    tick;
    drive(1, 1, 2, 63, 2, 63);
    chk("R3 equal rename ok", int'(in_ready), 1);
    drive(0, 1, 2, 63, 2, 63);
    counter(1, "R9/R11 rename counter", 1);
  endtask

  task automatic t_sch;
    drive(1, 3, 1, 63, 63, 2);
    chk("R4 short scheduler blocks", int'(in_ready), 0);
    tick;
    drive(1, 3, 1, 63, 63, 3);
    chk("R4 equal scheduler ok", int'(in_ready), 1);
    drive(0, 3, 1, 63, 63, 3);
    counter(2, "R9/R11 scheduler counter", 1);
  endtask

  task automatic t_prio;
    drive(1, 3, 3, 0, 0, 0); tick;
    drive(1, 3, 3, 63, 0, 0); tick;
    drive(0, 3, 3, 63, 63, 63);
    counter(0, "R5 rob charged first", 2);
    counter(1, "R5 rename charged second", 2);
    counter(2, "R5 scheduler never charged", 1);
  endtask

  task automatic t_carry;
    drive(1, 10, 1, 63, 63, 63);
    chk("R7 oversized admitted", int'(in_ready), 1);
    tick;
    chk("R8 oversized alloc", int'(alloc_uops), 10);
    drive(1, 1, 1, 63, 63, 63);
    chk("R7 carry 6 leaves no slot", int'(in_ready), 0);
    tick;
    drive(1, 3, 1, 0, 63, 63);
    chk("R6 carry 2 rejects 3", int'(in_ready), 0);
    tick;
    drive(1, 3, 1, 63, 63, 63);
    chk("R7 carry worked off", int'(in_ready), 1);
    tick;
    drive(1, 6, 1, 63, 63, 63); tick;
    drive(1, 2, 1, 63, 63, 63);
    chk("R6 exact fit with carry 2", int'(in_ready), 1);
    tick;
    chk("R8 alloc after exact fit", int'(alloc_uops), 2);
    drive(1, 4, 1, 63, 63, 63);
    chk("R6 full width after carry", int'(in_ready), 1);
    tick;
    drive(0, 1, 1, 63, 63, 63);
    counter(3, "R5/R9 bandwidth counter", 2);
    counter(0, "R5 rob not charged under bandwidth stall", 2);
  endtask

  task automatic t_sat;
    drive(1, 3, 1, 0, 63, 63);
    for (int i = 0; i < 70; i++) tick;
    drive(0, 3, 1, 63, 63, 63);
    counter(0, "R10 saturated", 63);
    drive(1, 3, 1, 0, 63, 63); tick;
    drive(0, 3, 1, 63, 63, 63);
    counter(0, "R10 no wrap", 63);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset; t_basic; t_rob; t_ren; t_sch; t_prio; t_carry; t_sat;
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule